// File: doc/BRIEF.md
# Reset and Strap Control Unit

This block sits beside the host-facing logic of a network controller and owns two jobs: remembering the configuration straps, and issuing resets that software asks for. While the chip is in power-on reset or an effective host reset, it samples a three-bit configuration strap group and a one-bit speed-up strap, and stores each bit inverted. The last values sampled before reset ends are kept. The low bit of the stored configuration field selects which identifier pair the device presents.

Software writes one 16-bit control word. Three self-clearing request bits start fixed-length reset pulses: a global pulse, a receive pulse and a transmit pulse. A six-bit domain selection field decides which downstream domains each pulse reaches. The receive and transmit pulses use only the low three selection bits, which stand for the network-interface, FIFO-control and DMA sub-domains. A polarity bit sets the active level of the reset output pin. A wake hold bit lets the device ignore the host reset while it sits in the lowest power state.

Top module: `rst_strap_ctrl`

Control word layout (write and read): bits [2:0] configuration field (read-only), bit 3 speed-up, bit 4 wake hold, bit 5 output polarity, bit 6 global request, bit 7 receive request, bit 8 transmit request, bits [14:9] domain selection, bit 15 reserved.

## Requirements
- R1: While `rst` is high or an effective host reset is active, bits [2:0] capture the bitwise inverse of `strap_cfg` on each clock edge. Once reset ends, the field holds the last captured value whatever `strap_cfg` does.
- R2: Writes never change bits [2:0]. Reserved codes 010 to 111 are stored like any other value.
- R3: When bit 0 of the configuration field is 1, `dev_id`/`ven_id` show the alternate pair (parameters DEV_ALT/VEN_ALT). When it is 0, they show the main pair (DEV_MAIN/VEN_MAIN).
- R4: Bit 3 takes the inverse of `strap_spd` during reset. After reset, software can write it and read it back.
- R5: Writing 1 to bit 6 starts a global pulse on the next edge. The pulse lasts exactly PULSE_LEN (16) cycles. `glb_dom_rst` equals the selection field [14:9] while the pulse runs and 0 otherwise. Bit 6 reads 1 during the pulse and 0 afterwards.
- R6: Bits 7 and 8 start receive and transmit pulses of the same length. `rx_sub_rst`/`tx_sub_rst` equal selection bits [11:9] while their pulse runs, and the request bit reads 1 meanwhile.
- R7: Writing 1 to a request bit while that pulse is running is ignored. The pulse neither restarts nor gets longer.
- R8: `rst_out` is asserted during reset and during a global pulse. It is active-high when bit 5 is 1 and active-low when bit 5 is 0.
- R9: If bit 4 is 1 and `pwr_d3` is high, a low `host_rst_n` has no effect. Otherwise a low `host_rst_n` resets the unit like `rst`: bits 4 and 5 clear, the selection returns to all ones, and the straps are re-captured.
- R10: A global pulse changes none of the stored fields and none of the identifier outputs.
- R11: Bit 15 reads 0 regardless of what is written to it.
- R12: After reset, bits 4 and 5 read 0, the selection reads 111111, and no pulse is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| host_rst_n | input | 1 | Host reset, active low |
| pwr_d3 | input | 1 | Device is in the lowest power state |
| strap_cfg | input | 3 | Configuration strap pins |
| strap_spd | input | 1 | Speed-up strap pin |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 16 | Control word write value |
| reg_rd_data | output | 16 | Control word read value |
| glb_dom_rst | output | 6 | Global reset per selected domain |
| rx_sub_rst | output | 3 | Receive reset per selected sub-domain |
| tx_sub_rst | output | 3 | Transmit reset per selected sub-domain |
| rst_out | output | 1 | Reset output pin, polarity set by bit 5 |
| dev_id | output | 16 | Presented device identifier |
| ven_id | output | 16 | Presented vendor identifier |

## Verification
Two cases can fall in the same cycle. In the first, a new request write arrives while a pulse is still running. The bench writes the global request again five cycles into a pulse and checks that exactly sixteen active cycles are counted in total. In the second, a host reset arrives while the device is in the lowest power state with the wake hold bit set. The bench changes the straps during that reset and checks that the configuration field, the hold bit and the reset output do not move. A second host reset with the power state cleared must then re-capture the new straps.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int REG_W   = 16;
    localparam int STRAP_N = 3;
    localparam int DOM_N   = 6;
    localparam int SUB_N   = 3;
    localparam int KIND_N  = 3;

    localparam int POS_CFG = 0;
    localparam int POS_SPD = 3;
    localparam int POS_WOL = 4;
    localparam int POS_POL = 5;
    localparam int POS_GO  = 6;
    localparam int POS_SEL = 9;
    localparam int POS_RSV = 15;

    typedef enum logic [1:0] {
        PK_GLB = 2'd0,
        PK_RX  = 2'd1,
        PK_TX  = 2'd2
    } pulse_kind_e;

    localparam logic [REG_W-1:0] RW_MASK =
        (REG_W'(1) << POS_SPD) | (REG_W'(1) << POS_WOL) |
        (REG_W'(1) << POS_POL) | (REG_W'((1 << DOM_N) - 1) << POS_SEL);

    typedef struct packed {
        logic [DOM_N-1:0] sel;
        logic             pol;
        logic             wol;
        logic             spd;
    } ctrl_view_t;

    function automatic ctrl_view_t decode_ctrl(input logic [REG_W-1:0] w);
        ctrl_view_t v;
        v.sel = w[POS_SEL +: DOM_N];
        v.pol = w[POS_POL];
        v.wol = w[POS_WOL];
        v.spd = w[POS_SPD];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] reset_word(input logic [DOM_N-1:0] sel_init,
                                                    input logic spd_strap);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_SEL +: DOM_N] = sel_init;
        w[POS_SPD]          = ~spd_strap;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] assemble_read(input logic [REG_W-1:0] rw,
                                                       input logic [STRAP_N-1:0] cfg,
                                                       input logic [KIND_N-1:0] act);
        logic [REG_W-1:0] w;
        w = rw & RW_MASK;
        w[POS_CFG +: STRAP_N] = cfg;
        w[POS_GO +: KIND_N]   = act;
        w[POS_RSV]            = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/rsc_strap_latch.sv
module rsc_strap_latch
    import rsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_any,
    input  logic [STRAP_N-1:0] strap_cfg,
    output logic [STRAP_N-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            cfg_q <= ~strap_cfg;
        end
    end

endmodule

// File: rtl/rsc_ctrl_reg.sv
module rsc_ctrl_reg
    import rsc_pkg::*;
#(
    parameter logic [DOM_N-1:0] SEL_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_any,
    input  logic             strap_spd,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rw_q
);

    logic [REG_W-1:0] rw_next;

    always_comb begin
        rw_next = rw_q;
        if (wr_en) begin
            rw_next = (rw_q & ~RW_MASK) | (wr_data & RW_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            rw_q <= reset_word(SEL_INIT, strap_spd);
        end else begin
            rw_q <= rw_next;
        end
    end

endmodule

// File: rtl/rsc_pulse_gen.sv
module rsc_pulse_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    output logic active
);

    localparam int CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (clr) begin
            active <= 1'b0;
            remain <= '0;
        end else if (active) begin
            if (remain == '0) begin
                active <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end else if (start) begin
            active <= 1'b1;
            remain <= CW'(PULSE_LEN - 1);
        end
    end

endmodule

// File: rtl/rsc_dom_gate.sv
module rsc_dom_gate
    import rsc_pkg::*;
(
    input  logic [KIND_N-1:0] act,
    input  logic [DOM_N-1:0]  sel,
    output logic [DOM_N-1:0]  glb_dom_rst,
    output logic [SUB_N-1:0]  rx_sub_rst,
    output logic [SUB_N-1:0]  tx_sub_rst
);

    for (genvar d = 0; d < DOM_N; d++) begin : g_dom
        assign glb_dom_rst[d] = act[PK_GLB] & sel[d];
    end

    for (genvar s = 0; s < SUB_N; s++) begin : g_sub
        assign rx_sub_rst[s] = act[PK_RX] & sel[s];
        assign tx_sub_rst[s] = act[PK_TX] & sel[s];
    end

endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
    import rsc_pkg::*;
#(
    parameter int               PULSE_LEN = 16,
    parameter logic [DOM_N-1:0] SEL_INIT  = '1,
    parameter int               ID_W      = 16,
    parameter logic [ID_W-1:0]  DEV_MAIN  = 16'hA5C1,
    parameter logic [ID_W-1:0]  VEN_MAIN  = 16'h5E17,
    parameter logic [ID_W-1:0]  DEV_ALT   = 16'hA5C2,
    parameter logic [ID_W-1:0]  VEN_ALT   = 16'h5E18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_rst_n,
    input  logic               pwr_d3,
    input  logic [STRAP_N-1:0] strap_cfg,
    input  logic               strap_spd,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wr_data,
    output logic [REG_W-1:0]   reg_rd_data,
    output logic [DOM_N-1:0]   glb_dom_rst,
    output logic [SUB_N-1:0]   rx_sub_rst,
    output logic [SUB_N-1:0]   tx_sub_rst,
    output logic               rst_out,
    output logic [ID_W-1:0]    dev_id,
    output logic [ID_W-1:0]    ven_id
);

    logic [REG_W-1:0]   rw_q;
    logic [STRAP_N-1:0] cfg_q;
    logic [KIND_N-1:0]  act;
    ctrl_view_t         view;
    logic               hrst_eff;
    logic               rst_any;
    logic               rst_asrt;

    assign view     = decode_ctrl(rw_q);
    assign hrst_eff = !host_rst_n && !(view.wol && pwr_d3);
    assign rst_any  = rst || hrst_eff;

    rsc_strap_latch u_strap (
        .clk       (clk),
        .rst_any   (rst_any),
        .strap_cfg (strap_cfg),
        .cfg_q     (cfg_q)
    );

    rsc_ctrl_reg #(
        .SEL_INIT (SEL_INIT)
    ) u_reg (
        .clk       (clk),
        .rst_any   (rst_any),
        .strap_spd (strap_spd),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .rw_q      (rw_q)
    );

    for (genvar k = 0; k < KIND_N; k++) begin : g_pulse
        rsc_pulse_gen #(
            .PULSE_LEN (PULSE_LEN)
        ) u_pg (
            .clk    (clk),
            .clr    (rst_any),
            .start  (reg_wr_en && reg_wr_data[POS_GO + k]),
            .active (act[k])
        );
    end

    rsc_dom_gate u_gate (
        .act         (act),
        .sel         (view.sel),
        .glb_dom_rst (glb_dom_rst),
        .rx_sub_rst  (rx_sub_rst),
        .tx_sub_rst  (tx_sub_rst)
    );

    assign rst_asrt    = rst_any || act[PK_GLB];
    assign rst_out     = view.pol ? rst_asrt : !rst_asrt;
    assign dev_id      = cfg_q[0] ? DEV_ALT : DEV_MAIN;
    assign ven_id      = cfg_q[0] ? VEN_ALT : VEN_MAIN;
    assign reg_rd_data = assemble_read(rw_q, cfg_q, act);

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
    import rsc_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rst_n,
    input logic              pwr_d3,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_rd_data,
    input logic [DOM_N-1:0]  glb_dom_rst,
    input logic [SUB_N-1:0]  rx_sub_rst,
    input logic [SUB_N-1:0]  tx_sub_rst,
    input logic              rst_out,
    input logic [KIND_N-1:0] act,
    input logic              hrst_eff
);

    logic [15:0] run_cnt;
    logic [DOM_N-1:0] sel_rd;

    assign sel_rd = reg_rd_data[POS_SEL +: DOM_N];

    always_ff @(posedge clk) begin
        if (rst || !act[PK_GLB]) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
        act[PK_GLB] |-> (run_cnt < 16'(PULSE_LEN)));                                   // R5
    AST_GLB_MASK: assert property (@(posedge clk) disable iff (rst)
        (glb_dom_rst & ~sel_rd) == '0);                                                 // R5
    AST_SUB_MASK: assert property (@(posedge clk) disable iff (rst)
        ((rx_sub_rst | tx_sub_rst) & ~sel_rd[SUB_N-1:0]) == '0);                        // R6
    AST_OUT_POL: assert property (@(posedge clk) disable iff (rst)
        act[PK_GLB] |-> (rst_out == reg_rd_data[POS_POL]));                             // R8
    AST_WOL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[POS_WOL] && pwr_d3 && !host_rst_n && !reg_wr_en) |=> reg_rd_data[POS_WOL]); // R9
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hrst_eff && !$past(hrst_eff) && !$past(rst)) |-> $stable(reg_rd_data[POS_CFG +: STRAP_N])); // R1

endmodule

bind rst_strap_ctrl rsc_checker #(
    .PULSE_LEN (PULSE_LEN)
) u_rsc_checker (
    .clk         (clk),
    .rst         (rst),
    .host_rst_n  (host_rst_n),
    .pwr_d3      (pwr_d3),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .glb_dom_rst (glb_dom_rst),
    .rx_sub_rst  (rx_sub_rst),
    .tx_sub_rst  (tx_sub_rst),
    .rst_out     (rst_out),
    .act         (act),
    .hrst_eff    (hrst_eff)
);

// File: tb/test_rst_strap_ctrl.sv
`timescale 1ns/1ps
module test_rst_strap_ctrl;

    localparam logic [15:0] DEV_MAIN = 16'hA5C1;
    localparam logic [15:0] VEN_MAIN = 16'h5E17;
    localparam logic [15:0] DEV_ALT  = 16'hA5C2;
    localparam logic [15:0] VEN_ALT  = 16'h5E18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rst_n = 1'b1;
    logic        pwr_d3 = 1'b0;
    logic [2:0]  strap_cfg = 3'b000;
    logic        strap_spd = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic [5:0]  glb_dom_rst;
    logic [2:0]  rx_sub_rst;
    logic [2:0]  tx_sub_rst;
    logic        rst_out;
    logic [15:0] dev_id;
    logic [15:0] ven_id;

    int checks = 0;
    int fails  = 0;

    logic [2:0] m_cfg;
    logic       m_spd, m_wol, m_pol;
    logic [5:0] m_sel;

    always #2 clk = ~clk;

    rst_strap_ctrl #(
        .PULSE_LEN (16), .SEL_INIT (6'h3F), .ID_W (16),
        .DEV_MAIN (DEV_MAIN), .VEN_MAIN (VEN_MAIN), .DEV_ALT (DEV_ALT), .VEN_ALT (VEN_ALT)
    ) i_rst_strap_ctrl (
        .clk (clk), .rst (rst), .host_rst_n (host_rst_n), .pwr_d3 (pwr_d3),
        .strap_cfg (strap_cfg), .strap_spd (strap_spd),
        .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
        .glb_dom_rst (glb_dom_rst), .rx_sub_rst (rx_sub_rst), .tx_sub_rst (tx_sub_rst),
        .rst_out (rst_out), .dev_id (dev_id), .ven_id (ven_id)
    );

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expected);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] go);
        return {1'b0, m_sel, go, m_pol, m_wol, m_spd, m_cfg};
    endfunction

    function automatic logic [15:0] pack_wr(input logic junk15, input logic [5:0] sel,
                                            input logic [2:0] go, input logic pol,
                                            input logic wol, input logic spd,
                                            input logic [2:0] junk_cfg);
        return {junk15, sel, go, pol, wol, spd, junk_cfg};
    endfunction

    function automatic logic idle_out();
        return m_pol ? 1'b0 : 1'b1;
    endfunction

    task automatic model_reset();
        m_cfg = ~strap_cfg;
        m_spd = ~strap_spd;
        m_wol = 1'b0;
        m_pol = 1'b0;
        m_sel = 6'h3F;
    endtask

    task automatic por(input logic [2:0] cfg, input logic spd);
        strap_cfg = cfg;
        strap_spd = spd;
        rst = 1'b1;
        step(); step(); step();
        model_reset();
        chk("R8 rst_out during reset", {31'd0, rst_out}, 32'd0);
        rst = 1'b0;
        step();
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        step();
        reg_wr_en   = 1'b0;
        m_spd = d[3];
        m_wol = d[4];
        m_pol = d[5];
        m_sel = d[14:9];
    endtask

    task automatic check_ids(input string req);
        chk(req, {dev_id, ven_id}, m_cfg[0] ? {DEV_ALT, VEN_ALT} : {DEV_MAIN, VEN_MAIN});
    endtask

    task automatic run_pulse(input logic [2:0] go, input logic pol, input logic spd,
                             input logic [5:0] sel, input logic [3:0] junk);
        int bad_glb = 0;
        int bad_sub = 0;
        int bad_out = 0;
        int bad_rd  = 0;
        logic [2:0] cfg_before;
        cfg_before = m_cfg;
        wr(pack_wr(junk[3], sel, go, pol, 1'b0, spd, junk[2:0]));
        for (int i = 0; i < 20; i++) begin
            logic on;
            on = (i < 16);
            if (glb_dom_rst !== ((go[0] && on) ? m_sel : 6'd0)) bad_glb++;
            if (rx_sub_rst !== ((go[1] && on) ? m_sel[2:0] : 3'd0)) bad_sub++;
            if (tx_sub_rst !== ((go[2] && on) ? m_sel[2:0] : 3'd0)) bad_sub++;
            if (rst_out !== ((go[0] && on) ? m_pol : idle_out())) bad_out++;
            if (reg_rd_data !== exp_read(on ? go : 3'b000)) bad_rd++;
            step();
        end
        chk("R5 global domains", bad_glb, 0);
        chk("R6 rx/tx sub-domains", bad_sub, 0);
        chk("R8 rst_out polarity", bad_out, 0);
        chk("R5 request bits readback", bad_rd, 0);
        chk("R10 fields after pulse", {16'd0, reg_rd_data}, {16'd0, exp_read(3'b000)});
        chk("R2 cfg not writable", {29'd0, reg_rd_data[2:0]}, {29'd0, cfg_before});
        check_ids("R10 ids after pulse");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        m_cfg = '0; m_spd = 1'b0; m_wol = 1'b0; m_pol = 1'b0; m_sel = '0;

        por(3'b110, 1'b1);
        chk("R12 reset state", {16'd0, reg_rd_data}, {16'd0, exp_read(3'b000)});
        chk("R1 inverted capture", {29'd0, reg_rd_data[2:0]}, 32'd1);
        chk("R4 speed-up inverted", {31'd0, reg_rd_data[3]}, 32'd0);
        chk("R12 no pulse", {20'd0, glb_dom_rst, rx_sub_rst, tx_sub_rst}, 32'd0);
        chk("R8 rst_out idle low-active", {31'd0, rst_out}, 32'd1);
        check_ids("R3 alternate ids");

        strap_cfg = 3'b001;
        strap_spd = 1'b0;
        step(); step();
        chk("R1 hold after release", {29'd0, reg_rd_data[2:0]}, 32'd1);

        wr(16'h8037);
        chk("R2 R11 R4 write mask", {16'd0, reg_rd_data}, {16'd0, exp_read(3'b000)});
        chk("R11 reserved zero", {31'd0, reg_rd_data[15]}, 32'd0);
        chk("R4 speed-up writable", {31'd0, reg_rd_data[3]}, 32'd0);
        chk("R8 idle active-high", {31'd0, rst_out}, 32'd0);

        por(3'b011, 1'b0);
        chk("R1 recapture", {29'd0, reg_rd_data[2:0]}, 32'd4);
        chk("R4 speed-up strap", {31'd0, reg_rd_data[3]}, 32'd1);
        check_ids("R3 main ids");

        run_pulse(3'b001, 1'b1, 1'b1, 6'b101101, 4'b0000);
        run_pulse(3'b110, 1'b0, 1'b0, 6'b010011, 4'b1111);
        run_pulse(3'b111, 1'b0, 1'b1, 6'b000000, 4'b1010);

        begin
            int n = 0;
            wr(pack_wr(1'b0, 6'h3F, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000));
            for (int i = 0; i < 25; i++) begin
                if (glb_dom_rst != 6'd0) n++;
                if (i == 4) begin
                    reg_wr_en   = 1'b1;
                    reg_wr_data = pack_wr(1'b0, 6'h3F, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000);
                    step();
                    reg_wr_en = 1'b0;
                end else begin
                    step();
                end
            end
            chk("R7 retrigger ignored", n, 16);
        end

        wr(pack_wr(1'b0, 6'h15, 3'b000, 1'b1, 1'b1, 1'b1, 3'b000));
        pwr_d3 = 1'b1;
        strap_cfg = 3'b111;
        host_rst_n = 1'b0;
        step();
        chk("R9 rst_out held", {31'd0, rst_out}, {31'd0, idle_out()});
        step(); step();
        chk("R9 host reset blocked", {16'd0, reg_rd_data}, {16'd0, exp_read(3'b000)});
        host_rst_n = 1'b1;
        step();
        chk("R9 wake hold kept", {31'd0, reg_rd_data[4]}, 32'd1);
        pwr_d3 = 1'b0;
        host_rst_n = 1'b0;
        step(); step();
        model_reset();
        host_rst_n = 1'b1;
        step();
        chk("R9 host reset outside D3", {16'd0, reg_rd_data}, {16'd0, exp_read(3'b000)});
        chk("R9 R1 straps recaptured", {29'd0, reg_rd_data[2:0]}, 32'd0);

        pwr_d3 = 1'b1;
        host_rst_n = 1'b0;
        strap_cfg = 3'b010;
        step(); step();
        model_reset();
        host_rst_n = 1'b1;
        step();
        chk("R9 D3 without hold resets", {16'd0, reg_rd_data}, {16'd0, exp_read(3'b000)});
        pwr_d3 = 1'b0;

        for (int it = 0; it < 12; it++) begin
            logic [31:0] r;
            logic [2:0] go;
            r = $urandom;
            if (it % 4 == 0) por(r[20:18], r[21]);
            go = r[2:0];
            if (go == 3'b000) go = 3'b001;
            run_pulse(go, r[3], r[4], r[10:5], r[14:11]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule